// File: doc/BRIEF.md
# Owner-Aware Address Translation Unit

This block translates the virtual addresses of one near-memory processing core into physical addresses. Each of its entries maps a 2 MB virtual page to a physical frame. Each entry also records which cache in the system is allowed to hold lines from that page. Every completed translation returns four things: the physical address, the owner-cache identifier, the memory vault that holds the data, and a routing class. The routing class tells the load/store path whether the line may be allocated in the local cache, must be sent to the owning cache, or must go straight to memory without being cached. Because ownership is decided per page, no directory lookup is needed to keep caches coherent.

The table is fully associative and a lookup takes one cycle. The unit does not walk page tables. On a miss, the controller leaves its lookup state, enters a fill-wait state and raises a refill request that carries the virtual page number. A host-side handler answers with the frame and the owner. The controller then installs the entry in the slot picked by a round-robin pointer, delivers the translation for the held request and returns to the lookup state. A single-cycle invalidate-all input empties the table when owner assignments change.

Controller states are `ST_LOOKUP` (accepting requests) and `ST_WAIT_FILL` (refill outstanding). The controller has two transitions:
- Lookup miss: `ST_LOOKUP` → `ST_WAIT_FILL`.
- Refill arrival: `ST_WAIT_FILL` → `ST_LOOKUP`.

A hit keeps the controller in `ST_LOOKUP`.

Top module: `owner_tlb`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, `miss_valid` is 0 and the table holds no valid entry, so the first lookup misses.
- R2: A request accepted on a hit (`req_valid` and `req_ready` high at an edge) gives `resp_valid`=1 in the next cycle. `resp_pa` is then the stored frame number placed above the request's low 21 address bits, which pass through unchanged.
- R3: A request accepted on a miss drops `req_ready` and raises `miss_valid` in the next cycle. `miss_vpn` equals the request's address bits above bit 20. Both stay unchanged, with no response and with later requests ignored, until a refill arrives.
- R4: A `fill_valid` pulse while `miss_valid` is high installs the held page with `fill_pfn` and `fill_owner`. In the next cycle the unit gives the response for the held request, with its original offset, and returns `req_ready` to 1. A later lookup of that page hits.
- R5: `resp_owner` equals the owner stored for the page. When it equals parameter `LOCAL_ID`, `resp_route` is 0 (local cacheable).
- R6: When `resp_owner` is all ones (no owning cache), `resp_route` is 2 (direct uncached memory access).
- R7: For any other owner, `resp_route` is 1 (forward to the owning cache; no local allocation).
- R8: `resp_vault` equals physical address bits [21 +: log2(VAULTS)], whatever the owner.
- R9: Refills fill slots in round-robin order starting at slot 0. With all `ENTRIES` slots used, the next refill evicts the oldest installed page, which then misses.
- R10: `inval_all` clears every valid entry in one cycle. A lookup presented in the same cycle misses, and a refill arriving in that cycle delivers its response but leaves no entry behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_va | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Unit accepts a request this cycle |
| resp_valid | output | 1 | Translation result valid |
| resp_pa | output | PA_W | Physical address |
| resp_owner | output | OWN_W | Owner-cache identifier of the page |
| resp_vault | output | log2(VAULTS) | Memory vault holding the address |
| resp_route | output | 2 | 0 local cacheable, 1 via owner cache, 2 direct uncached |
| miss_valid | output | 1 | Refill request outstanding |
| miss_vpn | output | VA_W-21 | Virtual page number to be refilled |
| fill_valid | input | 1 | Refill data present |
| fill_pfn | input | PA_W-21 | Physical frame number for the held page |
| fill_owner | input | OWN_W | Owner-cache identifier for the held page |
| inval_all | input | 1 | Clear all entries |

## Verification
The bench builds the unit with `ENTRIES`=4, `LOCAL_ID`=3 and a 4-bit owner field, and leaves the 16 vaults and address widths at their defaults. The small table brings slot wrap and eviction of the oldest page within a handful of refills. The narrow owner field puts the local, all-ones and other owner codes side by side. Frame numbers are chosen so that their low bits sweep several vault indices while the owner changes independently.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ROUTE_LOCAL_CACHE = 2'd0,
        ROUTE_VIA_OWNER   = 2'd1,
        ROUTE_DIRECT_MEM  = 2'd2
    } route_e;

    typedef enum logic [0:0] {
        ST_LOOKUP    = 1'b0,
        ST_WAIT_FILL = 1'b1
    } tlb_state_e;

    localparam int PAGE_SHIFT = 21;

endpackage

// File: rtl/tlb_array.sv
module tlb_array #(
    parameter int ENTRIES = 32,
    parameter int VPN_W   = 27,
    parameter int PFN_W   = 19,
    parameter int OWN_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [OWN_W-1:0] wr_owner,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    output logic [OWN_W-1:0] lk_owner
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] vld_q;
    logic [ENTRIES-1:0] hit_vec;
    logic [VPN_W-1:0]   tag_q [ENTRIES];
    logic [PFN_W-1:0]   pfn_q [ENTRIES];
    logic [OWN_W-1:0]   own_q [ENTRIES];
    logic [IDX_W-1:0]   victim_q;
    logic               install;

    assign install = wr_en && !clr_all;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q    <= '0;
            victim_q <= '0;
        end else if (clr_all) begin
            vld_q    <= '0;
        end else if (install) begin
            vld_q[victim_q] <= 1'b1;
            victim_q        <= (victim_q == LAST_IDX) ? '0 : victim_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[victim_q] <= wr_vpn;
            pfn_q[victim_q] <= wr_pfn;
            own_q[victim_q] <= wr_owner;
        end
    end

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign hit_vec[g] = vld_q[g] && (tag_q[g] == lk_vpn);
        end
    endgenerate

    assign lk_hit = (|hit_vec) && !clr_all;

    always_comb begin
        lk_pfn   = '0;
        lk_owner = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                lk_pfn   = lk_pfn | pfn_q[i];
                lk_owner = lk_owner | own_q[i];
            end
        end
    end
endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic lk_hit,
    input  logic fill_valid,
    output logic req_ready,
    output logic miss_valid,
    output logic take_hit,
    output logic take_miss,
    output logic take_fill
);
    tlb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOOKUP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOKUP:    if (req_valid && !lk_hit) state_d = ST_WAIT_FILL;
            ST_WAIT_FILL: if (fill_valid)           state_d = ST_LOOKUP;
            default:                                state_d = ST_LOOKUP;
        endcase
    end

    always_comb begin
        req_ready  = 1'b0;
        miss_valid = 1'b0;
        take_hit   = 1'b0;
        take_miss  = 1'b0;
        take_fill  = 1'b0;
        unique case (state_q)
            ST_LOOKUP: begin
                req_ready = 1'b1;
                take_hit  = req_valid && lk_hit;
                take_miss = req_valid && !lk_hit;
            end
            ST_WAIT_FILL: begin
                miss_valid = 1'b1;
                take_fill  = fill_valid;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tlb_route.sv
module tlb_route
    import tlb_pkg::*;
#(
    parameter int OWN_W    = 4,
    parameter int PFN_W    = 19,
    parameter int VAULT_W  = 4,
    parameter int LOCAL_ID = 3
) (
    input  logic [OWN_W-1:0]   owner,
    input  logic [PFN_W-1:0]   pfn,
    output route_e             route,
    output logic [VAULT_W-1:0] vault
);
    localparam logic [OWN_W-1:0] LOCAL_CODE = OWN_W'(LOCAL_ID);
    localparam logic [OWN_W-1:0] NONE_CODE  = '1;

    assign vault = pfn[VAULT_W-1:0];

    always_comb begin
        if (owner == LOCAL_CODE)     route = ROUTE_LOCAL_CACHE;
        else if (owner == NONE_CODE) route = ROUTE_DIRECT_MEM;
        else                         route = ROUTE_VIA_OWNER;
    end
endmodule

// File: rtl/owner_tlb.sv
module owner_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W     = 48,
    parameter int PA_W     = 40,
    parameter int ENTRIES  = 32,
    parameter int OWN_W    = 4,
    parameter int VAULTS   = 16,
    parameter int LOCAL_ID = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic [VA_W-1:0]             req_va,
    output logic                        req_ready,
    output logic                        resp_valid,
    output logic [PA_W-1:0]             resp_pa,
    output logic [OWN_W-1:0]            resp_owner,
    output logic [$clog2(VAULTS)-1:0]   resp_vault,
    output logic [1:0]                  resp_route,
    output logic                        miss_valid,
    output logic [VA_W-PAGE_SHIFT-1:0]  miss_vpn,
    input  logic                        fill_valid,
    input  logic [PA_W-PAGE_SHIFT-1:0]  fill_pfn,
    input  logic [OWN_W-1:0]            fill_owner,
    input  logic                        inval_all
);
    localparam int VPN_W   = VA_W - PAGE_SHIFT;
    localparam int PFN_W   = PA_W - PAGE_SHIFT;
    localparam int VAULT_W = $clog2(VAULTS);

    logic [VA_W-1:0]    held_va_q;
    logic               lk_hit;
    logic [PFN_W-1:0]   lk_pfn;
    logic [OWN_W-1:0]   lk_owner;
    logic               take_hit, take_miss, take_fill;
    logic [PFN_W-1:0]   src_pfn;
    logic [OWN_W-1:0]   src_owner;
    logic [PAGE_SHIFT-1:0] src_off;
    route_e             src_route;
    logic [VAULT_W-1:0] src_vault;

    tlb_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .lk_hit     (lk_hit),
        .fill_valid (fill_valid),
        .req_ready  (req_ready),
        .miss_valid (miss_valid),
        .take_hit   (take_hit),
        .take_miss  (take_miss),
        .take_fill  (take_fill)
    );

    tlb_array #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .OWN_W   (OWN_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_va[VA_W-1:PAGE_SHIFT]),
        .clr_all  (inval_all),
        .wr_en    (take_fill),
        .wr_vpn   (held_va_q[VA_W-1:PAGE_SHIFT]),
        .wr_pfn   (fill_pfn),
        .wr_owner (fill_owner),
        .lk_hit   (lk_hit),
        .lk_pfn   (lk_pfn),
        .lk_owner (lk_owner)
    );

    assign src_pfn   = take_fill ? fill_pfn   : lk_pfn;
    assign src_owner = take_fill ? fill_owner : lk_owner;
    assign src_off   = take_fill ? held_va_q[PAGE_SHIFT-1:0] : req_va[PAGE_SHIFT-1:0];

    tlb_route #(
        .OWN_W    (OWN_W),
        .PFN_W    (PFN_W),
        .VAULT_W  (VAULT_W),
        .LOCAL_ID (LOCAL_ID)
    ) u_route (
        .owner (src_owner),
        .pfn   (src_pfn),
        .route (src_route),
        .vault (src_vault)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_va_q  <= '0;
            resp_valid <= 1'b0;
            resp_pa    <= '0;
            resp_owner <= '0;
            resp_vault <= '0;
            resp_route <= 2'd0;
        end else begin
            if (take_miss) held_va_q <= req_va;
            resp_valid <= take_hit || take_fill;
            if (take_hit || take_fill) begin
                resp_pa    <= {src_pfn, src_off};
                resp_owner <= src_owner;
                resp_vault <= src_vault;
                resp_route <= src_route;
            end
        end
    end

    assign miss_vpn = held_va_q[VA_W-1:PAGE_SHIFT];
endmodule

// File: rtl/owner_tlb_chk.sv
module owner_tlb_chk #(
    parameter int PA_W     = 40,
    parameter int OWN_W    = 4,
    parameter int VAULT_W  = 4,
    parameter int VPN_W    = 27,
    parameter int LOCAL_ID = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic [PA_W-1:0]    resp_pa,
    input logic [OWN_W-1:0]   resp_owner,
    input logic [VAULT_W-1:0] resp_vault,
    input logic [1:0]         resp_route,
    input logic               miss_valid,
    input logic [VPN_W-1:0]   miss_vpn,
    input logic               fill_valid
);
    // R2
    resp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($past(req_valid && req_ready) || $past(miss_valid && fill_valid)));

    // R3
    miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && !fill_valid) |=> (miss_valid && $stable(miss_vpn) && !req_ready));

    // R3
    no_resp_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid |-> !resp_valid);

    // R4
    fill_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_valid && fill_valid) |=> (resp_valid && req_ready && !miss_valid));

    // R5
    local_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_owner == OWN_W'(LOCAL_ID)) |-> (resp_route == 2'd0));

    // R6
    none_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (&resp_owner)) |-> (resp_route == 2'd2));

    // R8
    vault_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_vault == resp_pa[21 +: VAULT_W]));
endmodule

bind owner_tlb owner_tlb_chk #(
    .PA_W     (PA_W),
    .OWN_W    (OWN_W),
    .VAULT_W  (VAULT_W),
    .VPN_W    (VPN_W),
    .LOCAL_ID (LOCAL_ID)
) u_owner_tlb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_pa    (resp_pa),
    .resp_owner (resp_owner),
    .resp_vault (resp_vault),
    .resp_route (resp_route),
    .miss_valid (miss_valid),
    .miss_vpn   (miss_vpn),
    .fill_valid (fill_valid)
);

// File: tb/test_owner_tlb.sv
module test_owner_tlb;
    localparam int VA_W = 48;
    localparam int PA_W = 40;
    localparam int ENT  = 4;
    localparam int OWN_W = 4;
    localparam int LID  = 3;
    localparam int VPN_W = VA_W - 21;
    localparam int PFN_W = PA_W - 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_va = '0;
    logic req_ready, resp_valid, miss_valid;
    logic [PA_W-1:0] resp_pa;
    logic [OWN_W-1:0] resp_owner;
    logic [3:0] resp_vault;
    logic [1:0] resp_route;
    logic [VPN_W-1:0] miss_vpn;
    logic fill_valid = 1'b0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic [OWN_W-1:0] fill_owner = '0;
    logic inval_all = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string phase = "R1";

    always #4 clk = ~clk;

    owner_tlb #(.VA_W(VA_W), .PA_W(PA_W), .ENTRIES(ENT), .OWN_W(OWN_W),
                .VAULTS(16), .LOCAL_ID(LID)) i_owner_tlb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_pa(resp_pa),
        .resp_owner(resp_owner), .resp_vault(resp_vault), .resp_route(resp_route),
        .miss_valid(miss_valid), .miss_vpn(miss_vpn), .fill_valid(fill_valid),
        .fill_pfn(fill_pfn), .fill_owner(fill_owner), .inval_all(inval_all));

    // behavioural reference: slot contents, wait flag, pointer, expectations
    bit              m_v [ENT];
    logic [VPN_W-1:0] m_vpn [ENT];
    logic [PFN_W-1:0] m_pfn [ENT];
    logic [OWN_W-1:0] m_own [ENT];
    int  m_ptr = 0;
    bit  m_wait = 1'b0;
    logic [VA_W-1:0] m_held = '0;
    bit  e_rv = 1'b0;
    logic [PA_W-1:0] e_pa = '0;
    logic [OWN_W-1:0] e_own = '0;

    function automatic logic [1:0] route_of(logic [OWN_W-1:0] o);
        if (o == OWN_W'(LID)) return 2'd0;
        if (&o) return 2'd2;
        return 2'd1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
            m_ptr = 0; m_wait = 1'b0; m_held = '0; e_rv = 1'b0;
        end else begin
            bit hit;
            int hi;
            hit = 1'b0; hi = 0;
            e_rv = 1'b0;
            if (!m_wait) begin
                if (req_valid) begin
                    for (int i = 0; i < ENT; i++)
                        if (m_v[i] && m_vpn[i] == req_va[VA_W-1:21]) begin hit = 1'b1; hi = i; end
                    if (inval_all) hit = 1'b0;
                    if (hit) begin
                        e_rv = 1'b1;
                        e_pa = {m_pfn[hi], req_va[20:0]};
                        e_own = m_own[hi];
                    end else begin
                        m_wait = 1'b1;
                        m_held = req_va;
                    end
                end
                if (inval_all) for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
            end else begin
                if (inval_all) for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
                if (fill_valid) begin
                    if (!inval_all) begin
                        m_v[m_ptr] = 1'b1;
                        m_vpn[m_ptr] = m_held[VA_W-1:21];
                        m_pfn[m_ptr] = fill_pfn;
                        m_own[m_ptr] = fill_owner;
                        m_ptr = (m_ptr + 1) % ENT;
                    end
                    e_rv = 1'b1;
                    e_pa = {fill_pfn, m_held[20:0]};
                    e_own = fill_owner;
                    m_wait = 1'b0;
                end
            end
        end
    end

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(phase, "req_ready", 64'(req_ready), 64'(!m_wait));
            chk(phase, "miss_valid", 64'(miss_valid), 64'(m_wait));
            chk(phase, "resp_valid", 64'(resp_valid), 64'(e_rv));
            if (m_wait) chk("R3", "miss_vpn", 64'(miss_vpn), 64'(m_held[VA_W-1:21]));
            if (e_rv) begin
                chk("R2", "resp_pa", 64'(resp_pa), 64'(e_pa));
                chk("R5", "resp_owner", 64'(resp_owner), 64'(e_own));
                chk((route_of(e_own) == 2'd0) ? "R5" : (route_of(e_own) == 2'd2) ? "R6" : "R7",
                    "resp_route", 64'(resp_route), 64'(route_of(e_own)));
                chk("R8", "resp_vault", 64'(resp_vault), 64'(e_pa[24:21]));
            end
        end
    end

    task automatic lookup(logic [VA_W-1:0] va);
        @(posedge clk); #1 req_valid = 1'b1; req_va = va;
        @(posedge clk); #1 req_valid = 1'b0;
        @(posedge clk);
    endtask

    task automatic refill(logic [PFN_W-1:0] pfn, logic [OWN_W-1:0] own, bit inv);
        @(posedge clk); #1 fill_valid = 1'b1; fill_pfn = pfn; fill_owner = own; inval_all = inv;
        @(posedge clk); #1 fill_valid = 1'b0; inval_all = 1'b0;
        @(posedge clk);
    endtask

    function automatic logic [VA_W-1:0] va_of(int page, int off);
        return {VPN_W'(page), 21'(off)};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state checked by the per-cycle compare; first lookup must miss
        phase = "R1";
        checks++;
        if (!(req_ready === 1'b1 && resp_valid === 1'b0 && miss_valid === 1'b0)) begin
            failures++;
            $display("FAIL R1 reset outputs actual=%b%b%b expected=100", req_ready, resp_valid, miss_valid);
        end
        lookup(va_of(10, 21'h1abcd));
        // R3: ignored request while waiting, miss held
        phase = "R3";
        lookup(va_of(77, 5));
        repeat (2) @(posedge clk);
        // R4: refill, owner local (R5)
        phase = "R4";
        refill(19'h00005, 4'(LID), 1'b0);
        // R2: hit with different offset
        phase = "R2";
        lookup(va_of(10, 21'h000ff));
        // R6: page with no owner
        phase = "R6";
        lookup(va_of(11, 21'h10000));
        refill(19'h0003a, 4'hf, 1'b0);
        lookup(va_of(11, 21'h00007));
        // R7: other owner; R8 vault sweep
        phase = "R7";
        lookup(va_of(12, 21'h1ffff));
        refill(19'h7fff9, 4'h5, 1'b0);
        lookup(va_of(12, 21'h00001));
        phase = "R8";
        lookup(va_of(13, 21'h00040));
        refill(19'h1234c, 4'h0, 1'b0);
        // R9: table now holds pages 10,11,12,13 in slots 0..3; next refill evicts page 10
        phase = "R9";
        lookup(va_of(14, 21'h00002));
        refill(19'h00107, 4'(LID), 1'b0);
        lookup(va_of(11, 21'h00003));
        lookup(va_of(10, 21'h00004));
        refill(19'h00008, 4'h2, 1'b0);
        lookup(va_of(12, 21'h00005));
        // R10: invalidate-all then lookups miss
        phase = "R10";
        @(posedge clk); #1 inval_all = 1'b1;
        @(posedge clk); #1 inval_all = 1'b0;
        lookup(va_of(10, 21'h00009));
        refill(19'h00011, 4'h1, 1'b1);
        lookup(va_of(10, 21'h0000a));
        refill(19'h00022, 4'h1, 1'b0);
        @(posedge clk); #1 req_valid = 1'b1; req_va = va_of(10, 21'h0000b); inval_all = 1'b1;
        @(posedge clk); #1 req_valid = 1'b0; inval_all = 1'b0;
        @(posedge clk);
        refill(19'h00033, 4'(LID), 1'b0);
        lookup(va_of(10, 21'h0000c));
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule